// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block gathers interrupt events from sixteen asynchronous source lines on a board logic device. It presents them to a host processor as one active-high level interrupt. Each source is brought into the local clock domain through a two-flop synchroniser. A rising edge of the synchronised source latches a pending bit for that line. A per-line enable mask decides which pending bits can raise the host interrupt.

The host uses a small 16-bit register port with one bit per line. The enable mask has two write addresses: one sets bits and one clears them, and in both cases zero bits leave their lines alone. Pending bits are cleared by writing ones to the status address. A further address shows the synchronised raw level of every source.

To quiesce the block, software writes all ones to the mask-clear address and then all ones to the status address.

Top module: `irqx_top`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, `irq_o` is low and `rdata_o` is 0.
- R2: A write to address 0x1A sets enable bit n for every 1 in bit n of `wdata_i` and leaves the other enable bits unchanged. A read of 0x1A returns the enable mask, where 1 means enabled.
- R3: A write to address 0x1C clears enable bit n for every 1 in bit n of `wdata_i` and leaves the other enable bits unchanged.
- R4: Pending bit n is set only by a 0-to-1 transition of synchronised source n. A source held high does not set its bit again after the bit has been cleared.
- R5: A write to address 0x16 clears pending bit n for every 1 in bit n of `wdata_i` and leaves the other pending bits unchanged. A read of 0x16 returns the pending bits.
- R6: If a new event and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when some line is both pending and enabled.
- R8: A read of address 0x18 returns the synchronised level of all sixteen sources, with bit n for source n.
- R9: Read data appears on `rdata_o` one cycle after `rd_en_i`. Addresses 0x1C and any unmapped address read as 0.
- R10: Events on disabled lines are still latched as pending, so enabling such a line later raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Asynchronous interrupt source lines |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Active-high level interrupt to the host |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` are valid at the clock edge. They also assume that a write strobe targets only one address per cycle. The stimulus drives every bus input on the falling edge and holds it for one full cycle. Source lines change on the falling edge and then stay stable for at least five cycles, so each change has passed through the synchroniser before the next one arrives. The one exception is the directed collision case. There, a clear write is timed to the exact cycle in which the event detector fires.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    parameter int unsigned NUM_LINES   = 16;
    parameter int unsigned ADDR_W      = 8;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [ADDR_W-1:0]    addr_t;

    localparam addr_t OFS_STATUS = addr_t'(8'h16);
    localparam addr_t OFS_RAW    = addr_t'(8'h18);
    localparam addr_t OFS_MSET   = addr_t'(8'h1A);
    localparam addr_t OFS_MCLR   = addr_t'(8'h1C);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_RAW,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    typedef struct packed {
        logic      set_mask;
        logic      clr_mask;
        logic      clr_stat;
        line_vec_t data;
    } wr_cmd_t;

    function automatic reg_sel_e decode_addr(input addr_t a);
        reg_sel_e s;
        case (a)
            OFS_STATUS: s = SEL_STATUS;
            OFS_RAW:    s = SEL_RAW;
            OFS_MSET:   s = SEL_MSET;
            OFS_MCLR:   s = SEL_MCLR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync
    import irqx_pkg::*;
#(
    parameter int unsigned WIDTH  = NUM_LINES,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] prev_q;

    for (genvar n = 0; n < WIDTH; n++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[n]};
            end
        end
        assign level_o[n] = chain_q[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;

    // R4: an edge pulse lasts one cycle only
    p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irqx_decode.sv
module irqx_decode
    import irqx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_t     addr_i,
    input  logic      wr_en_i,
    input  logic      rd_en_i,
    input  line_vec_t wdata_i,
    input  line_vec_t status_i,
    input  line_vec_t mask_i,
    input  line_vec_t raw_i,
    output wr_cmd_t   cmd_o,
    output line_vec_t rdata_o
);

    reg_sel_e  sel;
    line_vec_t rd_mux;
    line_vec_t rdata_q;

    assign sel = decode_addr(addr_i);

    always_comb begin
        cmd_o          = '0;
        cmd_o.data     = wdata_i;
        cmd_o.set_mask = wr_en_i && (sel == SEL_MSET);
        cmd_o.clr_mask = wr_en_i && (sel == SEL_MCLR);
        cmd_o.clr_stat = wr_en_i && (sel == SEL_STATUS);
    end

    always_comb begin
        case (sel)
            SEL_STATUS: rd_mux = status_i;
            SEL_RAW:    rd_mux = raw_i;
            SEL_MSET:   rd_mux = mask_i;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

    // R9: unmapped and mask-clear reads return zero one cycle later
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i != OFS_STATUS && addr_i != OFS_RAW && addr_i != OFS_MSET)
        |=> (rdata_o == '0));

    // R2: a mask read returns the mask seen at the read edge
    p_mask_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == OFS_MSET) |=> (rdata_o == $past(mask_i)));

    // at most one write target per cycle
    p_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_o.set_mask, cmd_o.clr_mask, cmd_o.clr_stat}));

endmodule

// File: rtl/irqx_state.sv
module irqx_state
    import irqx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_cmd_t   cmd_i,
    input  line_vec_t rise_i,
    output line_vec_t status_o,
    output line_vec_t mask_o
);

    line_vec_t status_q;
    line_vec_t mask_q;
    line_vec_t clr_bits;
    line_vec_t set_bits;
    line_vec_t off_bits;

    assign clr_bits = cmd_i.clr_stat ? cmd_i.data : '0;
    assign set_bits = cmd_i.set_mask ? cmd_i.data : '0;
    assign off_bits = cmd_i.clr_mask ? cmd_i.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            // a fresh event outranks a clear on the same bit
            status_q <= (status_q & ~clr_bits) | rise_i;
            mask_q   <= (mask_q | set_bits) & ~off_bits;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    // R2: written ones become enabled
    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_i.set_mask |=> ((mask_q & $past(cmd_i.data)) == $past(cmd_i.data)));

    // R3: written ones become disabled
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_i.clr_mask |=> ((mask_q & $past(cmd_i.data)) == '0));

    // R2/R3: mask is unchanged without a mask write
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.set_mask && !cmd_i.clr_mask) |=> $stable(mask_q));

    // R4 and R6: every detected edge is latched, even against a clear
    p_edge_latch_r6: assert property (@(posedge clk) disable iff (rst)
        (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

    // R4: pending bits appear only from detected edges
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_i)) == '0));

    // R5: cleared bits without a competing edge go to zero
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_i.clr_stat |=> ((status_q & $past(cmd_i.data & ~rise_i)) == '0));

endmodule

// File: rtl/irqx_top.sv
module irqx_top
    import irqx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] src_i,
    input  logic [7:0]  addr_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        irq_o
);

    line_vec_t level;
    line_vec_t rise;
    line_vec_t status;
    line_vec_t mask;
    wr_cmd_t   cmd;

    irqx_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_i),
        .level_o (level),
        .rise_o  (rise)
    );

    irqx_decode i_decode (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .wdata_i  (wdata_i),
        .status_i (status),
        .mask_i   (mask),
        .raw_i    (level),
        .cmd_o    (cmd),
        .rdata_o  (rdata_o)
    );

    irqx_state i_state (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .rise_i   (rise),
        .status_o (status),
        .mask_o   (mask)
    );

    assign irq_o = |(status & mask);

    // R7: nothing enabled means no interrupt
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

    // R1/R7: the output is low in the cycle after reset releases
    p_irq_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !irq_o);

endmodule

// File: tb/test_irqx_top.sv
module test_irqx_top;

    localparam time CLK_PERIOD = 10ns;

    localparam logic [7:0] A_STAT = 8'h16;
    localparam logic [7:0] A_RAW  = 8'h18;
    localparam logic [7:0] A_MSET = 8'h1A;
    localparam logic [7:0] A_MCLR = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_mask = '0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_src  = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqx_top i_irqx_top (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        case (a)
            A_STAT:  return m_stat;
            A_RAW:   return m_src;
            A_MSET:  return m_mask;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        case (a)
            A_MSET: m_mask = m_mask | d;
            A_MCLR: m_mask = m_mask & ~d;
            A_STAT: m_stat = m_stat & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_read_check(input logic [7:0] a, input string req);
        logic [15:0] e;
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        rd_en_i = 1'b0;
        check(rdata_o == e, req, rdata_o, e);
    endtask

    task automatic set_src(input logic [15:0] v);
        @(negedge clk);
        m_stat = m_stat | (v & ~m_src);
        m_src  = v;
        src_i  = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_irq(input string req);
        logic e;
        e = |(m_stat & m_mask);
        check(irq_o == e, req, {15'd0, irq_o}, {15'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(irq_o == 1'b0, "R1 irq", {15'd0, irq_o}, 16'h0);
        check(rdata_o == 16'h0, "R1 rdata", rdata_o, 16'h0);
        bus_read_check(A_MSET, "R1 mask");
        bus_read_check(A_STAT, "R1 status");

        // R10: events on disabled lines still latch
        set_src(16'h0005);
        bus_read_check(A_STAT, "R10 latched while masked");
        check_irq("R10 irq low while masked");
        bus_write(A_MSET, 16'h0004);
        check_irq("R10 irq after enable");
        bus_read_check(A_MSET, "R2 mask readback");
        bus_read_check(A_RAW, "R8 raw view");

        // R4: held source does not re-set after clear
        bus_write(A_STAT, 16'h0004);
        repeat (4) @(negedge clk);
        bus_read_check(A_STAT, "R4 held level no re-set");
        check_irq("R7 irq after clear");

        // R3: clear with zero bits leaves others
        bus_write(A_MSET, 16'hF0F0);
        bus_write(A_MCLR, 16'h3000);
        bus_read_check(A_MSET, "R3 partial clear");
        bus_read_check(A_MCLR, "R9 clear address reads zero");
        bus_read_check(8'h20, "R9 unmapped reads zero");

        // R6: event and clear in the same cycle
        set_src(16'h0000);
        bus_write(A_STAT, 16'hFFFF);
        @(negedge clk);
        src_i = 16'h0008;
        @(negedge clk);
        @(negedge clk);
        addr_i = A_STAT; wdata_i = 16'h0008; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        m_src  = 16'h0008;
        m_stat = m_stat | 16'h0008;
        repeat (3) @(negedge clk);
        bus_read_check(A_STAT, "R6 event beats clear");

        // random mix
        for (int i = 0; i < 80; i++) begin
            int op;
            logic [15:0] d;
            op = $urandom_range(0, 4);
            d  = 16'($urandom);
            case (op)
                0: set_src(d);
                1: bus_write(A_MSET, d);
                2: bus_write(A_MCLR, d);
                3: bus_write(A_STAT, d);
                default: ;
            endcase
            case ($urandom_range(0, 4))
                0: bus_read_check(A_STAT, "R5 status random");
                1: bus_read_check(A_MSET, "R2 mask random");
                2: bus_read_check(A_RAW, "R8 raw random");
                3: bus_read_check(A_MCLR, "R9 clear addr random");
                default: bus_read_check(8'($urandom_range(0, 15)), "R9 low address random");
            endcase
            check_irq("R7 irq random");
        end

        // shutdown sequence
        bus_write(A_MCLR, 16'hFFFF);
        bus_write(A_STAT, 16'hFFFF);
        bus_read_check(A_MSET, "R3 all disabled");
        bus_read_check(A_STAT, "R5 all cleared");
        check_irq("R7 quiet after shutdown");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule